// File: doc/BRIEF.md
# Data-Strobe Serial Transmit Encoder

This block turns parallel transmit words from a link-side interface into a data-strobe serial pair for one cable port. It runs from a single fast clock at four times the system rate. An internal divide-by-four phase counter marks the system-cycle boundaries and reports them on `sys_stb_o`, so the link side knows when its word is taken. A word is latched at a boundary and then shifted out MSB first. High-speed mode sends four bits per system cycle, one per fast clock. Low-speed mode sends only the two low bits, one on every second fast clock.

The serial pair follows the data-strobe rule. The data line carries the bit value. The strobe line toggles only when a bit repeats the previous data level, so data XOR strobe changes exactly once per bit. Between packets both lines hold their last level. Speed is chosen from `hi_speed_i` at the start of each packet and is held until the packet ends. When the port is switched to receive (`port_en_i` low), the line state is forced to an idle low level, the driver-enable output drops, and any offered words are ignored.

Top module: `ds_tx_encoder`

## Requirements
- R1: While reset is asserted, `data_o`, `strobe_o`, `drv_en_o` and `sys_stb_o` are 0. After reset is released, the first `sys_stb_o` pulse appears in the cycle after the third rising edge.
- R2: A word on `data_i` is latched only at a rising edge where `sys_stb_o`, `pkt_valid_i` and `port_en_i` are all high. When `pkt_valid_i` is low, `data_i` has no effect on the lines.
- R3: In high-speed mode (`hi_speed_i`=1), the latched word goes out as bits 3, 2, 1, 0. One bit is emitted on each of the four rising edges after the latch edge.
- R4: In low-speed mode (`hi_speed_i`=0), bit 1 is emitted on the first rising edge after the latch edge and bit 0 on the third. Bits 3:2 are ignored, and the lines hold on the second and fourth edges.
- R5: At each emitted bit, `data_o` takes the bit value. `strobe_o` inverts when the bit equals the previous `data_o` and holds otherwise, so `data_o ^ strobe_o` toggles once per bit.
- R6: When no packet is active, `data_o` and `strobe_o` keep their last levels.
- R7: The speed mode is captured with the first word of a packet. Changes on `hi_speed_i` while the packet continues do not affect it.
- R8: One edge after `port_en_i` goes low, `drv_en_o`, `data_o` and `strobe_o` are 0 and stay 0 while it is low, whatever is offered. After re-enable, `drv_en_o` is 1 one edge later, and encoding resumes from line levels 0/0.
- R9: `sys_stb_o` is high for one cycle in every four.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit-rate clock, four times the system rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| port_en_i | input | 1 | 1 = transmit, 0 = port receiving (drivers off) |
| pkt_valid_i | input | 1 | Word on `data_i` is part of a packet |
| hi_speed_i | input | 1 | 1 = four bits per system cycle, 0 = two bits |
| data_i | input | 4 | Parallel transmit word |
| sys_stb_o | output | 1 | Last fast cycle of a system cycle; the word is taken at its end |
| data_o | output | 1 | Serial data line |
| strobe_o | output | 1 | Serial strobe line |
| drv_en_o | output | 1 | Enable for the analog line drivers |

## Verification
Counting the latch edge as edge 0, the bit for phase k is emitted on edge k+1. The bench therefore samples 1 ns after each of the four following edges and checks a bit only where the selected speed emits one. Disable and re-enable take effect one edge after `port_en_i` changes, and the checks are placed at that edge. Next words and the end of the packet are driven in the `sys_stb_o` cycle. The expected strobe level is carried across bits, so one wrong toggle is reported at every later bit of the packet.

// File: rtl/ds_tx_pkg.sv
package ds_tx_pkg;
  typedef enum logic {
    SPD_LOW  = 1'b0,
    SPD_HIGH = 1'b1
  } speed_e;
endpackage

// File: rtl/ds_phase_gen.sv
module ds_phase_gen #(
  parameter int DIV = 4,
  localparam int PH_W = $clog2(DIV)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [PH_W-1:0] phase_o,
  output logic            sys_stb_o
);
  logic [PH_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + PH_W'(1);
  end

  assign phase_o   = cnt_q;
  assign sys_stb_o = (cnt_q == PH_W'(DIV - 1));

  // R9
  stb_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_stb_o |=> !sys_stb_o && (phase_o == '0));
endmodule

// File: rtl/ds_word_latch.sv
module ds_word_latch
  import ds_tx_pkg::*;
#(
  parameter int WORD_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stb_i,
  input  logic              port_en_i,
  input  logic              pkt_valid_i,
  input  logic              hi_speed_i,
  input  logic [WORD_W-1:0] data_i,
  output logic [WORD_W-1:0] word_o,
  output logic              act_o,
  output speed_e            speed_o
);
  logic [WORD_W-1:0] word_q;
  logic              act_q;
  speed_e            spd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      act_q  <= 1'b0;
      spd_q  <= SPD_LOW;
    end else if (!port_en_i) begin
      act_q <= 1'b0;
    end else if (stb_i) begin
      act_q <= pkt_valid_i;
      if (pkt_valid_i) begin
        word_q <= data_i;
        // speed locks on the first word of a packet
        if (!act_q) spd_q <= speed_e'(hi_speed_i);
      end
    end
  end

  assign word_o  = word_q;
  assign act_o   = act_q;
  assign speed_o = spd_q;

  // R2
  latch_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_i && port_en_i && pkt_valid_i) |=> act_o && (word_o == $past(data_i)));

  // R6
  latch_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_i && !pkt_valid_i) |=> !act_o);

  // R7
  speed_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_o && stb_i && pkt_valid_i && port_en_i) |=> $stable(speed_o));
endmodule

// File: rtl/ds_serializer.sv
module ds_serializer
  import ds_tx_pkg::*;
#(
  parameter int WORD_W   = 4,
  parameter int NARROW_W = 2,
  localparam int PH_W    = $clog2(WORD_W),
  localparam int LO_STEP = WORD_W / NARROW_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              port_en_i,
  input  logic              act_i,
  input  speed_e            speed_i,
  input  logic [PH_W-1:0]   phase_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              data_o,
  output logic              strobe_o,
  output logic              drv_en_o
);
  logic [PH_W-1:0] idx;
  logic            slot;
  logic            fire;
  logic            bit_v;
  logic            d_q, s_q, en_q;

  always_comb begin
    if (speed_i == SPD_HIGH) begin
      slot = 1'b1;
      idx  = PH_W'(WORD_W - 1) - phase_i;
    end else begin
      slot = ((phase_i % PH_W'(LO_STEP)) == '0);
      idx  = PH_W'(NARROW_W - 1) - (phase_i / PH_W'(LO_STEP));
    end
    fire  = slot && act_i && port_en_i;
    bit_v = word_i[idx];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      d_q  <= 1'b0;
      s_q  <= 1'b0;
      en_q <= 1'b0;
    end else begin
      en_q <= port_en_i;
      if (!port_en_i) begin
        d_q <= 1'b0;
        s_q <= 1'b0;
      end else if (fire) begin
        d_q <= bit_v;
        s_q <= (bit_v == d_q) ? ~s_q : s_q;
      end
    end
  end

  assign data_o   = d_q;
  assign strobe_o = s_q;
  assign drv_en_o = en_q;

  // R5
  ds_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> ((data_o ^ strobe_o) != $past(data_o ^ strobe_o)));

  // R6
  line_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (port_en_i && !fire) |=> $stable({data_o, strobe_o}));

  // R8
  idle_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !drv_en_o |-> (!data_o && !strobe_o));
endmodule

// File: rtl/ds_tx_encoder.sv
module ds_tx_encoder
  import ds_tx_pkg::*;
#(
  parameter int WORD_W   = 4,
  parameter int NARROW_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              port_en_i,
  input  logic              pkt_valid_i,
  input  logic              hi_speed_i,
  input  logic [WORD_W-1:0] data_i,
  output logic              sys_stb_o,
  output logic              data_o,
  output logic              strobe_o,
  output logic              drv_en_o
);
  localparam int PH_W = $clog2(WORD_W);

  logic [PH_W-1:0]   phase;
  logic              stb;
  logic [WORD_W-1:0] word;
  logic              act;
  speed_e            spd;

  ds_phase_gen #(.DIV(WORD_W)) u_phase (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .phase_o   (phase),
    .sys_stb_o (stb)
  );

  ds_word_latch #(.WORD_W(WORD_W)) u_latch (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .stb_i       (stb),
    .port_en_i   (port_en_i),
    .pkt_valid_i (pkt_valid_i),
    .hi_speed_i  (hi_speed_i),
    .data_i      (data_i),
    .word_o      (word),
    .act_o       (act),
    .speed_o     (spd)
  );

  ds_serializer #(.WORD_W(WORD_W), .NARROW_W(NARROW_W)) u_ser (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .port_en_i (port_en_i),
    .act_i     (act),
    .speed_i   (spd),
    .phase_i   (phase),
    .word_i    (word),
    .data_o    (data_o),
    .strobe_o  (strobe_o),
    .drv_en_o  (drv_en_o)
  );

  assign sys_stb_o = stb;
endmodule

// File: tb/sim_ds_tx_encoder.sv
module sim_ds_tx_encoder;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       port_en_i = 1'b1;
  logic       pkt_valid_i = 1'b0;
  logic       hi_speed_i = 1'b0;
  logic [3:0] data_i = 4'h0;
  logic       sys_stb_o, data_o, strobe_o, drv_en_o;

  int   checks = 0;
  int   fails = 0;
  logic exp_d = 1'b0;
  logic exp_s = 1'b0;

  ds_tx_encoder u0 (
    .clk_i(clk), .rst_ni(rst_ni), .port_en_i(port_en_i),
    .pkt_valid_i(pkt_valid_i), .hi_speed_i(hi_speed_i), .data_i(data_i),
    .sys_stb_o(sys_stb_o), .data_o(data_o), .strobe_o(strobe_o),
    .drv_en_o(drv_en_o)
  );

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic emit(input logic b, input string req);
    if (b == exp_d) exp_s = ~exp_s;
    exp_d = b;
    chk(data_o == exp_d, req, data_o, exp_d);
    chk(strobe_o == exp_s, "R5 strobe", strobe_o, exp_s);
  endtask

  task automatic hold(input string req);
    chk(data_o == exp_d, req, data_o, exp_d);
    chk(strobe_o == exp_s, req, strobe_o, exp_s);
  endtask

  function automatic logic [3:0] word_of(input int s, input int i);
    return 4'(s + i * 5);
  endfunction

  task automatic sync_stb();
    do @(negedge clk); while (!sys_stb_o);
  endtask

  task automatic run_pkt(input bit hs, input int n, input int seed, input bit flip);
    logic [3:0] cur, nxt;
    sync_stb();
    hi_speed_i = hs;
    pkt_valid_i = 1'b1;
    cur = word_of(seed, 0);
    nxt = cur;
    data_i = cur;
    @(posedge clk);
    for (int i = 0; i < n; i++) begin
      for (int k = 0; k < 4; k++) begin
        @(posedge clk); #1;
        if (hs) emit(cur[3-k], flip ? "R7 high" : "R3");
        else if (k % 2 == 0) emit(cur[1-k/2], flip ? "R7 low" : "R4");
        else hold("R4 hold");
        if (k == 2) begin
          if (flip) hi_speed_i = ~hs;
          if (i < n - 1) begin
            nxt = word_of(seed, i + 1);
            data_i = nxt;
          end else begin
            pkt_valid_i = 1'b0;
            data_i = 4'hA;
          end
        end
      end
      cur = nxt;
    end
  endtask

  task automatic idle_run(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      data_i = 4'(i * 7 + 3);
      hi_speed_i = i[0];
      @(posedge clk); #1;
      hold("R2 R6 idle");
    end
  endtask

  initial begin
    #400000;
    fails++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int cnt;
    bit prev, dbl;
    #10;
    // R1 reset state
    chk(!data_o && !strobe_o, "R1 lines", {data_o, strobe_o}, 0);
    chk(!drv_en_o, "R1 drv_en", drv_en_o, 0);
    chk(!sys_stb_o, "R1 stb", sys_stb_o, 0);
    @(negedge clk);
    rst_ni = 1'b1;
    repeat (2) @(posedge clk);
    #1 chk(!sys_stb_o, "R1 stb early", sys_stb_o, 0);
    @(posedge clk);
    #1 chk(sys_stb_o, "R1 stb first", sys_stb_o, 1);
    chk(drv_en_o, "R1 drv_en on", drv_en_o, 1);

    // R9 strobe cadence
    cnt = 0; prev = 1'b1; dbl = 1'b0;
    for (int i = 0; i < 16; i++) begin
      @(posedge clk); #1;
      if (sys_stb_o) cnt++;
      if (sys_stb_o && prev) dbl = 1'b1;
      prev = sys_stb_o;
    end
    chk(cnt == 4, "R9 count", cnt, 4);
    chk(!dbl, "R9 single", dbl, 0);

    idle_run(6);
    run_pkt(1'b1, 16, 0, 1'b0);   // all 16 words, high speed
    idle_run(8);
    run_pkt(1'b0, 16, 3, 1'b0);   // low speed, upper bits vary
    idle_run(8);
    run_pkt(1'b0, 4, 7, 1'b1);    // R7: speed flips mid-packet
    idle_run(5);
    run_pkt(1'b1, 4, 9, 1'b1);    // R7
    idle_run(5);

    // R8 disable
    @(negedge clk);
    port_en_i = 1'b0;
    pkt_valid_i = 1'b1;
    hi_speed_i = 1'b1;
    data_i = 4'hF;
    @(posedge clk); #1;
    chk(!drv_en_o, "R8 drv_en off", drv_en_o, 0);
    chk(!data_o && !strobe_o, "R8 idle level", {data_o, strobe_o}, 0);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      data_i = 4'(i * 3);
      @(posedge clk); #1;
      chk(!data_o && !strobe_o && !drv_en_o, "R8 held off",
          {drv_en_o, data_o, strobe_o}, 0);
    end
    exp_d = 1'b0;
    exp_s = 1'b0;
    @(negedge clk);
    pkt_valid_i = 1'b0;
    port_en_i = 1'b1;
    @(posedge clk); #1;
    chk(drv_en_o, "R8 drv_en back", drv_en_o, 1);
    run_pkt(1'b1, 3, 1, 1'b0);
    idle_run(4);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule